// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter. A small register file gives software a channel select, a control/status byte and a result split over two bytes. On the analog side the block drives a multiplexer select and a trial code for a DAC, and it reads back one comparator bit that says whether the selected input is at or above that trial code. The block runs a binary search on the comparator, one result bit per converter clock, starting at the most significant bit.

The converter clock is the system clock divided by a prescaler that software selects. A conversion runs once per start request in single mode. In free-running mode it repeats back to back. The first conversion after the block is switched on takes longer, to allow the analog side to settle. Each finished conversion raises a completion flag. The flag can be routed to an interrupt request. A read of the low result byte freezes the result registers until the high byte has been read, so that a pair of byte reads always returns both halves of the same conversion.

Register addresses are 0 for the channel select (bits 2:0), 1 for the control byte, 2 for the low result byte and 3 for the high result byte. The control byte bits are: 0 enable, 1 start/busy, 2 free-running, 3 completion flag, 4 interrupt enable, 7:5 prescaler select.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, all four register reads return 0, `irqReq` is 0, `muxSel` is 0 and `dacCode` is 0.
- R2: The stored result is the largest code C such that the input is at or above C, found MSB first with `cmpHigh` = 1 meaning the input is at or above `dacCode`. An input of 0 gives 0 and an input of 1023 gives 1023.
- R3: A normal conversion lasts 13 converter clocks. The first conversion after the enable bit goes from 0 to 1 lasts 25. The flag is visible right after the edge that ends the last converter clock, counted from the edge that accepts the start write.
- R4: Prescaler select values 0 through 7 divide the system clock by 2, 2, 4, 8, 16, 32, 64 and 128.
- R5: In single mode (bit 2 = 0), writing the control byte with enable and start set begins exactly one conversion. Bit 1 reads 1 while the conversion runs and 0 after it ends. No further conversion follows.
- R6: In free-running mode (bit 2 = 1), one start produces conversions back to back, each 13 converter clocks long. Clearing bit 2 lets the conversion in progress end, and the block then goes idle.
- R7: `muxSel` takes the channel register value only when a conversion begins. A channel write during a conversion does not change `muxSel` until the next conversion begins.
- R8: The flag (bit 3) is set at the end of every conversion. It is cleared by writing the control byte with bit 3 = 1, or by `irqAck`. Writing bit 3 = 0 leaves it unchanged.
- R9: `irqReq` is 1 exactly when the flag and the interrupt enable (bit 4) are both 1.
- R10: After a read of address 2, the result is not updated until address 3 is read. A conversion that ends while the result is frozen is discarded.
- R11: Writing the control byte with bit 0 = 0 aborts a running conversion. The aborted conversion sets no flag, and busy reads 0.
- R12: Address 3 returns result bits 9:8 in its bits 1:0, and its other bits read 0. Address 2 returns result bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (drives the result freeze side effects) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| irqAck | input | 1 | Interrupt acknowledge; clears the flag |
| irqReq | output | 1 | Interrupt request |
| muxSel | output | 3 | Analog multiplexer channel select |
| dacCode | output | 10 | Trial code for the comparison DAC |
| cmpHigh | input | 1 | Comparator: 1 when the input is at or above `dacCode` |

## Verification
The assertions assume that `cmpHigh` settles within the same system clock cycle as `dacCode`. The bench meets this with an ideal combinational comparator against a stored input value, and it changes that value only while no conversion runs. The assertions also assume that software does not write the channel register, or read the low result byte, in the same cycle in which a conversion starts or ends. The bench keeps these accesses apart in time. A full sweep of all 1024 input codes checks the search, and a sweep of all eight prescaler settings checks conversion length.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CHAN   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RES_LO = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_RES_HI = 2'd3;

  // control byte bit positions
  localparam int CB_EN      = 0;
  localparam int CB_START   = 1;
  localparam int CB_FREE    = 2;
  localparam int CB_FLAG    = 3;
  localparam int CB_IE      = 4;
  localparam int CB_PRE_LSB = 5;

  // strobes from sequencing control to the datapath
  typedef struct packed {
    logic convBegin;   // latch channel, clear trial register
    logic trialInit;   // end of sample phase: present MSB trial
    logic bitDecide;   // keep or drop current trial bit, arm next
    logic convFinish;  // transfer trial register to result
  } seqStrobe_t;

endpackage

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int NORM_CYC = 13,
  parameter int LONG_CYC = 25,
  parameter int PRE_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              irqAck,
  output seqStrobe_t        stb,
  output logic [7:0]        ctlByte,
  output logic              convBusy,
  output logic              irqReq
);

  localparam int CNT_W = $clog2(LONG_CYC);
  localparam int DIV_W = (1 << PRE_W) - 1;
  localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] INIT_OFS  = CNT_W'(RES_BITS + 1);
  localparam logic [CNT_W-1:0] DEC_OFS   = CNT_W'(RES_BITS);

  logic             enable, freeRun, irqEn, doneFlag, firstPending, busy, longConv;
  logic [PRE_W-1:0] presSel;
  logic [DIV_W-1:0] preCnt, divLast;
  logic [CNT_W-1:0] cycCnt, lastCyc;
  logic             wrCtl, enRise, startReq, abortReq, tick, restart;

  always_comb begin
    wrCtl    = regWrEn && (regAddr == ADDR_CTRL);
    enRise   = wrCtl && regWrData[CB_EN] && !enable;
    startReq = wrCtl && regWrData[CB_EN] && regWrData[CB_START] && !busy;
    abortReq = wrCtl && !regWrData[CB_EN] && busy;
    // select 0 and 1 both divide by two
    divLast  = (presSel < PRE_W'(2)) ? DIV_W'(1)
                                     : DIV_W'((32'd1 << presSel) - 32'd1);
    lastCyc  = longConv ? LONG_LAST : NORM_LAST;
    tick     = busy && (preCnt == divLast) && !abortReq;

    stb.trialInit  = tick && (cycCnt == lastCyc - INIT_OFS);
    stb.bitDecide  = tick && (cycCnt >= lastCyc - DEC_OFS) && (cycCnt < lastCyc);
    stb.convFinish = tick && (cycCnt == lastCyc);
    restart        = stb.convFinish && freeRun;
    stb.convBegin  = startReq || restart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable       <= 1'b0;
      freeRun      <= 1'b0;
      irqEn        <= 1'b0;
      presSel      <= '0;
      doneFlag     <= 1'b0;
      firstPending <= 1'b0;
      busy         <= 1'b0;
      longConv     <= 1'b0;
      preCnt       <= '0;
      cycCnt       <= '0;
    end else begin
      if (wrCtl) begin
        enable  <= regWrData[CB_EN];
        freeRun <= regWrData[CB_FREE];
        irqEn   <= regWrData[CB_IE];
        presSel <= regWrData[CB_PRE_LSB +: PRE_W];
      end
      if (enRise) firstPending <= 1'b1;

      if (abortReq) begin
        busy <= 1'b0;
      end else if (startReq) begin
        busy         <= 1'b1;
        cycCnt       <= '0;
        preCnt       <= '0;
        longConv     <= firstPending || enRise;
        firstPending <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          preCnt <= '0;
          if (stb.convFinish) begin
            if (freeRun) begin
              cycCnt   <= '0;
              longConv <= 1'b0;
            end else begin
              busy <= 1'b0;
            end
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end

      if (stb.convFinish)
        doneFlag <= 1'b1;
      else if ((wrCtl && regWrData[CB_FLAG]) || irqAck)
        doneFlag <= 1'b0;
    end
  end

  assign ctlByte  = 8'({presSel, irqEn, doneFlag, freeRun, busy, enable});
  assign convBusy = busy;
  assign irqReq   = doneFlag && irqEn;

endmodule

// File: rtl/sar_adc_dp.sv
module sar_adc_dp
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int MUX_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [MUX_W-1:0]    chanWrData,
  input  seqStrobe_t          stb,
  input  logic                cmpHigh,
  output logic [MUX_W-1:0]    muxSel,
  output logic [MUX_W-1:0]    chanSel,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] resultVal,
  output logic                resLocked
);

  localparam int PTR_W = $clog2(RES_BITS);

  logic [RES_BITS-1:0] sarReg, sarNext;
  logic [PTR_W-1:0]    bitPtr;

  // keep the trial bit if the input is at or above the trial code, then arm the next one
  always_comb begin
    sarNext = sarReg;
    if (!cmpHigh) sarNext[bitPtr] = 1'b0;
    if (bitPtr != '0) sarNext[bitPtr - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanSel   <= '0;
      muxSel    <= '0;
      sarReg    <= '0;
      bitPtr    <= '0;
      resultVal <= '0;
      resLocked <= 1'b0;
    end else begin
      if (regWrEn && (regAddr == ADDR_CHAN)) chanSel <= chanWrData;

      if (stb.convBegin) begin
        muxSel <= chanSel;
        sarReg <= '0;
      end else if (stb.trialInit) begin
        sarReg <= {1'b1, {(RES_BITS-1){1'b0}}};
        bitPtr <= PTR_W'(RES_BITS - 1);
      end else if (stb.bitDecide) begin
        sarReg <= sarNext;
        if (bitPtr != '0) bitPtr <= bitPtr - 1'b1;
      end

      if (stb.convFinish && !resLocked) resultVal <= sarReg;

      if (regRdEn && (regAddr == ADDR_RES_LO))
        resLocked <= 1'b1;
      else if (regRdEn && (regAddr == ADDR_RES_HI))
        resLocked <= 1'b0;
    end
  end

  assign dacCode = sarReg;

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int MUX_W    = 3,
  parameter int NORM_CYC = 13,
  parameter int LONG_CYC = 25,
  parameter int PRE_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [1:0]          regAddr,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic                irqAck,
  output logic                irqReq,
  output logic [MUX_W-1:0]    muxSel,
  output logic [RES_BITS-1:0] dacCode,
  input  logic                cmpHigh
);

  seqStrobe_t          stb;
  logic [7:0]          ctlByte;
  logic                convBusy;
  logic [MUX_W-1:0]    chanSel;
  logic [RES_BITS-1:0] resultVal;
  logic                resLocked;

  sar_adc_ctrl #(
    .RES_BITS(RES_BITS), .NORM_CYC(NORM_CYC), .LONG_CYC(LONG_CYC), .PRE_W(PRE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .irqAck(irqAck), .stb(stb), .ctlByte(ctlByte),
    .convBusy(convBusy), .irqReq(irqReq)
  );

  sar_adc_dp #(.RES_BITS(RES_BITS), .MUX_W(MUX_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .chanWrData(regWrData[MUX_W-1:0]), .stb(stb),
    .cmpHigh(cmpHigh), .muxSel(muxSel), .chanSel(chanSel), .dacCode(dacCode),
    .resultVal(resultVal), .resLocked(resLocked)
  );

  always_comb begin
    case (regAddr)
      ADDR_CHAN:   regRdData = 8'(chanSel);
      ADDR_CTRL:   regRdData = ctlByte;
      ADDR_RES_LO: regRdData = resultVal[7:0];
      default:     regRdData = 8'(resultVal >> 8);
    endcase
  end

endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int MUX_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [1:0]          regAddr,
  input logic                wrEnBit,
  input logic                irqAck,
  input logic [MUX_W-1:0]    muxSel,
  input logic [RES_BITS-1:0] dacCode,
  input seqStrobe_t          stb,
  input logic                flagBit,
  input logic                convBusy,
  input logic [RES_BITS-1:0] resultVal,
  input logic                resLocked
);

  logic wrDisable;
  assign wrDisable = regWrEn && (regAddr == ADDR_CTRL) && !wrEnBit;

  assert_mux_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.convBegin |=> $stable(muxSel));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.convFinish |=> flagBit);

  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !stb.convFinish) |=> !flagBit);

  assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    resLocked |=> $stable(resultVal));

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrDisable |=> !convBusy);

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.trialInit, stb.bitDecide, stb.convFinish}));

  assert_dac_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!convBusy && !stb.convBegin) |=> $stable(dacCode));

endmodule

bind sar_adc_seq sar_adc_chk #(.RES_BITS(RES_BITS), .MUX_W(MUX_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .wrEnBit(regWrData[sar_adc_pkg::CB_EN]), .irqAck(irqAck), .muxSel(muxSel),
  .dacCode(dacCode), .stb(stb), .flagBit(ctlByte[sar_adc_pkg::CB_FLAG]),
  .convBusy(convBusy), .resultVal(resultVal), .resLocked(resLocked)
);

// File: tb/sim_sar_adc_seq.sv
`timescale 1ns/1ps
module sim_sar_adc_seq;

  logic       clk = 1'b0;
  logic       rstN, regWrEn, regRdEn, irqAck, irqReq, cmpHigh;
  logic [1:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [2:0] muxSel;
  logic [9:0] dacCode, vin;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign cmpHigh = (vin >= dacCode);  // ideal comparator

  sar_adc_seq u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqAck(irqAck), .irqReq(irqReq), .muxSel(muxSel), .dacCode(dacCode),
    .cmpHigh(cmpHigh)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input int en, input int st, input int fr,
                                     input int clr, input int ie, input int pre);
    return 8'(en | (st << 1) | (fr << 2) | (clr << 3) | (ie << 4) | (pre << 5));
  endfunction

  function automatic int divOf(input int p);
    return (p < 2) ? 2 : (1 << p);
  endfunction

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output int d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = int'(regRdData);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // counts edges from the accepting write edge until the flag reads 1
  task automatic waitFlag(output int k);
    k = 0;
    do begin
      @(negedge clk);
      regAddr = 2'd1;
      k++;
      #1;
    end while (!regRdData[3] && k < 5000);
  endtask

  task automatic readResult(output int r);
    int lo, hi;
    rdReg(2'd2, lo);
    rdReg(2'd3, hi);
    r = (hi << 8) | lo;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, k, r, k1, k2;
    rstN = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0; irqAck = 1'b0;
    regAddr = 2'd0; regWrData = 8'd0; vin = 10'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(2'(a), d);
      check("R1 reg read", d, 0);
    end
    check("R1 irqReq", int'(irqReq), 0);
    check("R1 muxSel", int'(muxSel), 0);
    check("R1 dacCode", int'(dacCode), 0);

    // R3 first conversion after enable is long
    wrReg(2'd1, ctl(1, 0, 0, 0, 0, 0));
    vin = 10'd700;
    wrReg(2'd1, ctl(1, 1, 0, 1, 0, 0));
    waitFlag(k);
    check("R3 long conversion edges", k, 25 * 2);
    readResult(r);
    check("R2 result 700", r, 700);

    // R4 prescaler sweep, normal length
    for (int p = 0; p < 8; p++) begin
      vin = 10'(100 + p * 111);
      wrReg(2'd1, ctl(1, 1, 0, 1, 0, p));
      waitFlag(k);
      check("R4 conversion edges for prescaler", k, 13 * divOf(p));
      readResult(r);
      check("R2 result in prescaler sweep", r, 100 + p * 111);
    end

    // R2 and R12 exhaustive input sweep
    for (int v = 0; v < 1024; v++) begin
      int lo, hi;
      vin = 10'(v);
      wrReg(2'd1, ctl(1, 1, 0, 1, 0, 0));
      waitFlag(k);
      rdReg(2'd2, lo);
      rdReg(2'd3, hi);
      check("R2 sweep result", (hi << 8) | lo, v);
      check("R12 high byte upper bits", hi >> 2, 0);
    end

    // R5 single mode: busy bit and no repeat
    vin = 10'd55;
    wrReg(2'd1, ctl(1, 1, 0, 1, 0, 2));
    rdReg(2'd1, d);
    check("R5 busy while converting", (d >> 1) & 1, 1);
    waitFlag(k);
    rdReg(2'd1, d);
    check("R5 busy after end", (d >> 1) & 1, 0);
    wrReg(2'd1, ctl(1, 0, 0, 1, 0, 2));
    repeat (200) @(negedge clk);
    rdReg(2'd1, d);
    check("R5 no further conversion flag", (d >> 3) & 1, 0);
    check("R5 no further conversion busy", (d >> 1) & 1, 0);

    // R8 / R9 flag and interrupt
    vin = 10'd300;
    wrReg(2'd1, ctl(1, 1, 0, 1, 1, 0));
    waitFlag(k);
    check("R9 irq with flag and enable", int'(irqReq), 1);
    wrReg(2'd1, ctl(1, 0, 0, 0, 0, 0));
    check("R9 irq masked", int'(irqReq), 0);
    rdReg(2'd1, d);
    check("R8 write of 0 keeps flag", (d >> 3) & 1, 1);
    wrReg(2'd1, ctl(1, 0, 0, 0, 1, 0));
    check("R9 irq unmasked", int'(irqReq), 1);
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    check("R8 ack clears irq", int'(irqReq), 0);
    rdReg(2'd1, d);
    check("R8 ack clears flag", (d >> 3) & 1, 0);
    wrReg(2'd1, ctl(1, 1, 0, 0, 1, 0));
    waitFlag(k);
    wrReg(2'd1, ctl(1, 0, 0, 1, 1, 0));
    rdReg(2'd1, d);
    check("R8 write-one clears flag", (d >> 3) & 1, 0);
    check("R9 irq after clear", int'(irqReq), 0);

    // R6 / R7 free running with channel change mid-conversion
    wrReg(2'd0, 8'd5);
    vin = 10'd400;
    wrReg(2'd1, ctl(1, 1, 1, 1, 0, 1));
    k1 = 0; k2 = 0;
    for (int kk = 1; kk <= 200; kk++) begin
      @(negedge clk);
      regWrEn = 1'b0; irqAck = 1'b0; regAddr = 2'd1;
      if (kk == 1) check("R7 channel latched at start", int'(muxSel), 5);
      if (kk == 5) begin regAddr = 2'd0; regWrData = 8'd2; regWrEn = 1'b1; end
      if (kk == 8) check("R7 channel held during conversion", int'(muxSel), 5);
      if (kk == 28) check("R7 new channel at next conversion", int'(muxSel), 2);
      #1;
      if (regAddr == 2'd1 && regRdData[3]) begin
        if (k1 == 0) k1 = kk; else k2 = kk;
        irqAck = 1'b1;
      end
      if (k2 != 0) break;
    end
    @(negedge clk); irqAck = 1'b0;
    check("R6 first free-run conversion edges", k1, 26);
    check("R6 second free-run conversion edges", k2, 52);
    wrReg(2'd1, ctl(1, 0, 0, 1, 0, 1));
    repeat (100) @(negedge clk);
    rdReg(2'd1, d);
    check("R6 idle after leaving free-run", (d >> 1) & 1, 0);
    readResult(r);
    check("R2 free-run result", r, 400);

    // R10 result freeze between byte reads
    vin = 10'd100;
    wrReg(2'd1, ctl(1, 1, 0, 1, 0, 0));
    waitFlag(k);
    rdReg(2'd2, d);
    check("R10 low byte before freeze", d, 100);
    vin = 10'd900;
    wrReg(2'd1, ctl(1, 1, 0, 1, 0, 0));
    waitFlag(k);
    rdReg(2'd3, d);
    check("R10 high byte still old", d, 0);
    rdReg(2'd2, d);
    check("R10 frozen conversion discarded", d, 100);
    rdReg(2'd3, d);
    wrReg(2'd1, ctl(1, 1, 0, 1, 0, 0));
    waitFlag(k);
    rdReg(2'd2, d);
    check("R12 low byte of 900", d, 132);
    rdReg(2'd3, d);
    check("R12 high byte of 900", d, 3);

    // R11 abort, then R3 long conversion again
    vin = 10'd10;
    wrReg(2'd1, ctl(1, 1, 0, 1, 0, 0));
    repeat (10) @(negedge clk);
    wrReg(2'd1, 8'd0);
    repeat (80) @(negedge clk);
    rdReg(2'd1, d);
    check("R11 no flag after abort", (d >> 3) & 1, 0);
    check("R11 not busy after abort", (d >> 1) & 1, 0);
    wrReg(2'd1, ctl(1, 1, 0, 1, 0, 0));
    waitFlag(k);
    check("R3 long conversion after re-enable", k, 50);
    readResult(r);
    check("R11 result after re-enable", r, 10);
    wrReg(2'd1, ctl(1, 1, 0, 1, 0, 0));
    waitFlag(k);
    check("R3 normal conversion follows", k, 26);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule